// File: doc/BRIEF.md
# Multi-Select SPI Master Timing Sequencer

This block is a serial peripheral master that drives four active-low peripheral select lines. Each line has its own clock divisor, its own settling time between select assertion and the first clock, and its own hold time after the last bit. A separate global setting inserts idle time whenever the engine moves from one peripheral to a different one. The engine can therefore serve a fast device and a slow device in turn without any reprogramming between transfers.

Configuration is written one field at a time through a small write port. A transfer starts when a request is accepted. Each request carries a select index and one byte. The engine shifts the byte out MSB first and captures a byte from MISO at the same time. When the select is released it raises a one-cycle done pulse together with the received byte. If the requested select still has a divisor of zero, the engine refuses the request and raises an error pulse instead.

Top module: `spi_seq_master`

## Requirements
- R1: After reset all four selects are high, SCK and MOSI are low, `req_ready` is high, `xfer_done` and `div_err` are low, and every timing field reads as zero.
- R2: A write with `cfg_we` high stores `cfg_wdata` into the field chosen by `cfg_field` for the select chosen by `cfg_sel`. The field codes are: 0 divisor, 1 lead delay, 2 trail delay, 3 global switch delay. Code 3 ignores `cfg_sel`.
- R3: During shifting, SCK idles low and each bit takes a low half-period followed by a high half-period. Each half-period lasts exactly DIV system clock cycles, where DIV is the divisor of the active select. One transfer is 8 bits.
- R4: MOSI presents bit 7 first and holds each bit for that bit's full low and high half-periods. It changes only where SCK falls. MISO is sampled where SCK rises, and `rx_data` holds the received byte, MSB first, in the cycle `xfer_done` is high.
- R5: A request accepted while the requested select's divisor is zero starts nothing. Every select stays high, and `div_err` is high for exactly the next cycle.
- R6: If the accepted select differs from the select of the last started transfer, every select stays high for the global switch delay (in cycles) before the new select is asserted. No such gap occurs for the first transfer or for a repeat of the same select.
- R7: The chosen select is low, with SCK low, for exactly its lead-delay cycles before the first low half-period begins.
- R8: After the last high half-period, the select stays low with SCK low for exactly its trail-delay cycles, then returns high.
- R9: At most one select is low at any time, and all selects are high whenever the engine is idle. MOSI is low outside shifting.
- R10: `req_ready` is high exactly while idle, and a request is accepted at a clock edge where `req_valid` and `req_ready` are both high. `xfer_done` pulses for one cycle in the first idle cycle after the select is released. A new request may be accepted in that same cycle.
- R11: Timing fields are captured when a request is accepted. A write in the same cycle as the acceptance, or during the transfer, affects only later transfers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Select whose field is written |
| cfg_field | input | 2 | Field code: 0 divisor, 1 lead, 2 trail, 3 switch |
| cfg_wdata | input | 8 | Value written |
| req_valid | input | 1 | Transfer request |
| req_sel | input | 2 | Select index of the request |
| req_data | input | 8 | Byte to send |
| req_ready | output | 1 | Engine idle, request will be accepted |
| xfer_done | output | 1 | One-cycle pulse after select release |
| rx_data | output | 8 | Byte captured from MISO |
| div_err | output | 1 | One-cycle pulse: request refused, divisor zero |
| spi_sck | output | 1 | Serial clock, idles low |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs_n | output | 4 | Active-low peripheral selects |

## Verification
Two events can land in the same cycle. One is the done pulse of a finished transfer. The other is the acceptance of the next request, which in one case also coincides with a configuration write to the select being started. The bench provokes the first by queuing each request while the previous transfer is still running, so the engine takes it in its first idle cycle. It provokes the second by raising a divisor write and a request in the same cycle. A behavioural model expands every accepted request into a per-cycle list of expected select, SCK and MOSI values, using the timing fields as they stood before that cycle's write. Any overlap, missed gap or use of the new value shows up as a mismatch on the next compared cycle.

// File: rtl/spi_seq_pkg.sv
// Shared types for the multi-select SPI sequencer.
// Assumes the timing fields of every select share one width.
package spi_seq_pkg;
    localparam int unsigned TIME_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SWGAP,
        ST_LEAD,
        ST_SHIFT,
        ST_TRAIL
    } seq_state_e;

    typedef enum logic [1:0] {
        FLD_DIV    = 2'd0,
        FLD_LEAD   = 2'd1,
        FLD_TRAIL  = 2'd2,
        FLD_SWITCH = 2'd3
    } cfg_field_e;

    typedef struct packed {
        logic [TIME_W-1:0] div;
        logic [TIME_W-1:0] lead;
        logic [TIME_W-1:0] trail;
    } sel_timing_t;
endpackage

// File: rtl/spi_seq_cfg.sv
// Timing register bank: one entry of divisor, lead and trail per select, plus
// one global switch delay. Writes take effect at the clock edge. Reads are
// combinational and indexed by the requesting select.
module spi_seq_cfg
    import spi_seq_pkg::*;
#(
    parameter int NUM_SEL = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cfg_we,
    input  logic [$clog2(NUM_SEL)-1:0] cfg_sel,
    input  logic [1:0]                 cfg_field,
    input  logic [TIME_W-1:0]          cfg_wdata,
    input  logic [$clog2(NUM_SEL)-1:0] rd_sel,
    output sel_timing_t                rd_timing,
    output logic [TIME_W-1:0]          switch_dly
);
    localparam int SEL_W = $clog2(NUM_SEL);

    sel_timing_t entry_w [NUM_SEL];

    for (genvar g = 0; g < NUM_SEL; g++) begin : g_entry
        sel_timing_t entry_q;
        // Update this select's entry on a matching write.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                entry_q <= '0;
            end else if (cfg_we && cfg_sel == SEL_W'(g)) begin
                case (cfg_field)
                    FLD_DIV:   entry_q.div   <= cfg_wdata;
                    FLD_LEAD:  entry_q.lead  <= cfg_wdata;
                    FLD_TRAIL: entry_q.trail <= cfg_wdata;
                    default:   entry_q       <= entry_q;
                endcase
            end
        end
        assign entry_w[g] = entry_q;
    end

    // Hold the global select-switch delay.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            switch_dly <= '0;
        end else if (cfg_we && cfg_field == FLD_SWITCH) begin
            switch_dly <= cfg_wdata;
        end
    end

    assign rd_timing = entry_w[rd_sel];
endmodule

// File: rtl/spi_seq_shifter.sv
// Byte shifter: loads the transmit byte on acceptance, advances MOSI on each
// shift strobe (SCK fall) and collects MISO on each sample strobe (SCK rise).
// Assumes the strobes never coincide with a load.
module spi_seq_shifter #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] load_data,
    input  logic              shift_en,
    input  logic              sample_en,
    input  logic              miso,
    output logic              tx_bit,
    output logic [DATA_W-1:0] rx_data
);
    logic [DATA_W-1:0] tx_q;

    // Transmit register: load, then move the next bit into the MSB.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_q <= '0;
        end else if (load) begin
            tx_q <= load_data;
        end else if (shift_en) begin
            tx_q <= {tx_q[DATA_W-2:0], 1'b0};
        end
    end

    // Receive register: append MISO at each rising SCK.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_data <= '0;
        end else if (sample_en) begin
            rx_data <= {rx_data[DATA_W-2:0], miso};
        end
    end

    assign tx_bit = tx_q[DATA_W-1];
endmodule

// File: rtl/spi_seq_ctrl.sv
// Transfer sequencer. On an accepted request it captures that select's timing
// and walks through: switch gap (when the select changes), lead delay,
// DATA_W bits of low/high half-periods, trail delay. Zero-length phases are
// skipped. Assumes rd_timing reflects req_sel in the same cycle.
module spi_seq_ctrl
    import spi_seq_pkg::*;
#(
    parameter int NUM_SEL = 4,
    parameter int DATA_W  = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       req_valid,
    input  logic [$clog2(NUM_SEL)-1:0] req_sel,
    input  sel_timing_t                rd_timing,
    input  logic [TIME_W-1:0]          switch_dly,
    output seq_state_e                 state_q,
    output logic [$clog2(NUM_SEL)-1:0] sel_q,
    output logic                       half_q,
    output logic                       load,
    output logic                       shift_en,
    output logic                       sample_en,
    output logic                       done_q,
    output logic                       err_q
);
    localparam int SEL_W = $clog2(NUM_SEL);
    localparam int BIT_W = $clog2(DATA_W);
    localparam logic [BIT_W-1:0]  TOP_BIT = BIT_W'(DATA_W - 1);
    localparam logic [TIME_W-1:0] ONE     = TIME_W'(1);

    seq_state_e        state_d;
    logic [TIME_W-1:0] cnt_q, cnt_d;
    logic [BIT_W-1:0]  bit_q, bit_d;
    logic              half_d, finish;
    logic [TIME_W-1:0] div_q, lead_q, trail_q;
    logic [SEL_W-1:0]  prev_sel_q;
    logic              prev_vld_q;

    wire accept    = (state_q == ST_IDLE) && req_valid;
    wire refuse    = accept && (rd_timing.div == '0);
    wire start     = accept && !refuse;
    wire switching = prev_vld_q && (req_sel != prev_sel_q);

    assign load = start;

    // Next-phase selection and per-phase countdown.
    always_comb begin
        state_d   = state_q;
        cnt_d     = cnt_q;
        half_d    = half_q;
        bit_d     = bit_q;
        shift_en  = 1'b0;
        sample_en = 1'b0;
        finish    = 1'b0;
        unique case (state_q)
            ST_IDLE: if (start) begin
                if (switching && switch_dly != '0) begin
                    state_d = ST_SWGAP; cnt_d = switch_dly - ONE;
                end else if (rd_timing.lead != '0) begin
                    state_d = ST_LEAD;  cnt_d = rd_timing.lead - ONE;
                end else begin
                    state_d = ST_SHIFT; cnt_d = rd_timing.div - ONE;
                    half_d  = 1'b0;     bit_d = TOP_BIT;
                end
            end
            ST_SWGAP: if (cnt_q != '0) begin
                cnt_d = cnt_q - ONE;
            end else if (lead_q != '0) begin
                state_d = ST_LEAD;  cnt_d = lead_q - ONE;
            end else begin
                state_d = ST_SHIFT; cnt_d = div_q - ONE;
                half_d  = 1'b0;     bit_d = TOP_BIT;
            end
            ST_LEAD: if (cnt_q != '0) begin
                cnt_d = cnt_q - ONE;
            end else begin
                state_d = ST_SHIFT; cnt_d = div_q - ONE;
                half_d  = 1'b0;     bit_d = TOP_BIT;
            end
            ST_SHIFT: if (cnt_q != '0) begin
                cnt_d = cnt_q - ONE;
            end else if (!half_q) begin
                half_d = 1'b1; cnt_d = div_q - ONE; sample_en = 1'b1;
            end else if (bit_q != '0) begin
                half_d = 1'b0; bit_d = bit_q - 1'b1;
                cnt_d  = div_q - ONE; shift_en = 1'b1;
            end else if (trail_q != '0) begin
                state_d = ST_TRAIL; cnt_d = trail_q - ONE; half_d = 1'b0;
            end else begin
                state_d = ST_IDLE; half_d = 1'b0; finish = 1'b1;
            end
            ST_TRAIL: if (cnt_q != '0) begin
                cnt_d = cnt_q - ONE;
            end else begin
                state_d = ST_IDLE; finish = 1'b1;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Phase state, counters and status pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            half_q  <= 1'b0;
            bit_q   <= '0;
            done_q  <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            half_q  <= half_d;
            bit_q   <= bit_d;
            done_q  <= finish;
            err_q   <= refuse;
        end
    end

    // Capture the requesting select's timing at acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q      <= '0;
            prev_sel_q <= '0;
            prev_vld_q <= 1'b0;
            div_q      <= '0;
            lead_q     <= '0;
            trail_q    <= '0;
        end else if (start) begin
            sel_q      <= req_sel;
            prev_sel_q <= req_sel;
            prev_vld_q <= 1'b1;
            div_q      <= rd_timing.div;
            lead_q     <= rd_timing.lead;
            trail_q    <= rd_timing.trail;
        end
    end

    assert_refuse_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        refuse |=> (state_q == ST_IDLE) && err_q);
    assert_div_nonzero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |-> (div_q != '0));
    assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q);
    assert_done_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> (state_q == ST_IDLE));
endmodule

// File: rtl/spi_seq_master.sv
// Multi-select SPI master top: register bank, sequencer and shifter, with the
// select, SCK and MOSI pins decoded from the sequencer state. Mode is fixed:
// SCK idles low, MOSI changes on the falling edge, MISO is sampled on the rising edge.
module spi_seq_master
    import spi_seq_pkg::*;
#(
    parameter int NUM_SEL = 4,
    parameter int DATA_W  = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cfg_we,
    input  logic [$clog2(NUM_SEL)-1:0] cfg_sel,
    input  logic [1:0]                 cfg_field,
    input  logic [TIME_W-1:0]          cfg_wdata,
    input  logic                       req_valid,
    input  logic [$clog2(NUM_SEL)-1:0] req_sel,
    input  logic [DATA_W-1:0]          req_data,
    output logic                       req_ready,
    output logic                       xfer_done,
    output logic [DATA_W-1:0]          rx_data,
    output logic                       div_err,
    output logic                       spi_sck,
    output logic                       spi_mosi,
    input  logic                       spi_miso,
    output logic [NUM_SEL-1:0]         spi_cs_n
);
    localparam int SEL_W = $clog2(NUM_SEL);

    sel_timing_t       timing_w;
    logic [TIME_W-1:0] switch_w;
    seq_state_e        state_w;
    logic [SEL_W-1:0]  sel_w;
    logic              half_w, load_w, shift_w, sample_w, tx_bit_w;

    spi_seq_cfg #(.NUM_SEL(NUM_SEL)) cfg_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_field(cfg_field), .cfg_wdata(cfg_wdata), .rd_sel(req_sel),
        .rd_timing(timing_w), .switch_dly(switch_w)
    );

    spi_seq_ctrl #(.NUM_SEL(NUM_SEL), .DATA_W(DATA_W)) ctrl_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_sel(req_sel),
        .rd_timing(timing_w), .switch_dly(switch_w), .state_q(state_w),
        .sel_q(sel_w), .half_q(half_w), .load(load_w), .shift_en(shift_w),
        .sample_en(sample_w), .done_q(xfer_done), .err_q(div_err)
    );

    spi_seq_shifter #(.DATA_W(DATA_W)) shift_i (
        .clk(clk), .rst_n(rst_n), .load(load_w), .load_data(req_data),
        .shift_en(shift_w), .sample_en(sample_w), .miso(spi_miso),
        .tx_bit(tx_bit_w), .rx_data(rx_data)
    );

    wire cs_active = (state_w == ST_LEAD) || (state_w == ST_SHIFT) ||
                     (state_w == ST_TRAIL);

    for (genvar g = 0; g < NUM_SEL; g++) begin : g_cs
        assign spi_cs_n[g] = !(cs_active && sel_w == SEL_W'(g));
    end

    assign req_ready = (state_w == ST_IDLE);
    assign spi_sck   = (state_w == ST_SHIFT) && half_w;
    assign spi_mosi  = (state_w == ST_SHIFT) && tx_bit_w;

    assert_cs_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~spi_cs_n));
    assert_sck_needs_cs_R3: assert property (@(posedge clk) disable iff (!rst_n)
        spi_sck |-> (spi_cs_n != '1));
    assert_mosi_on_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state_w == ST_SHIFT) && state_w == ST_SHIFT &&
         spi_mosi != $past(spi_mosi)) |-> $fell(spi_sck));
    assert_idle_released_R9: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (spi_cs_n == '1 && !spi_sck));
endmodule

// File: tb/spi_seq_master_tb.sv
// Bench: behavioural per-cycle model of the pins, compared on every falling clock edge.
module spi_seq_master_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [1:0] cfg_sel = '0;
    logic [1:0] cfg_field = '0;
    logic [7:0] cfg_wdata = '0;
    logic       req_valid = 1'b0;
    logic [1:0] req_sel = '0;
    logic [7:0] req_data = '0;
    logic       req_ready, xfer_done, div_err, spi_sck, spi_mosi, spi_miso;
    logic [7:0] rx_data;
    logic [3:0] spi_cs_n;

    int tests = 0;
    int fails = 0;
    int cycles = 0;
    bit model_on = 1'b0;
    string scen = "R1";

    spi_seq_master dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_field(cfg_field), .cfg_wdata(cfg_wdata), .req_valid(req_valid),
        .req_sel(req_sel), .req_data(req_data), .req_ready(req_ready),
        .xfer_done(xfer_done), .rx_data(rx_data), .div_err(div_err),
        .spi_sck(spi_sck), .spi_mosi(spi_mosi), .spi_miso(spi_miso),
        .spi_cs_n(spi_cs_n)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Simple peripheral: presents its byte MSB first, next bit after each SCK fall.
    logic [7:0] slv = '0;
    logic [7:0] miso_byte = '0;
    assign spi_miso = slv[7];
    always @(negedge spi_sck) slv <= {slv[6:0], 1'b0};

    // Model state.
    typedef struct packed {
        logic [3:0] cs;
        logic       sck;
        logic       mosi;
        logic [3:0] tag;
    } exp_t;
    exp_t       q[$];
    logic [7:0] rxq[$];
    logic [7:0] m_div[4], m_lead[4], m_trail[4];
    logic [7:0] m_sw = '0;
    bit         prev_vld = 1'b0;
    logic [1:0] prev_sel = '0;
    bit         done_pend = 1'b0;
    bit         err_pend = 1'b0;

    function automatic string tag_name(input logic [3:0] t);
        case (t)
            4'd3: return "R3";
            4'd6: return "R6";
            4'd7: return "R7";
            4'd8: return "R8";
            default: return "R9";
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s (%s) at cycle %0d: actual %0h expected %0h",
                     req, scen, cycles, act, exp);
        end
    endtask

    // Expand an accepted transfer into its expected per-cycle pin values.
    task automatic push_xfer(input logic [1:0] s, input logic [7:0] d);
        logic [3:0] act;
        act = ~(4'b0001 << s);
        if (prev_vld && s != prev_sel)
            repeat (int'(m_sw)) q.push_back('{4'hF, 1'b0, 1'b0, 4'd6});
        prev_vld = 1'b1;
        prev_sel = s;
        repeat (int'(m_lead[s])) q.push_back('{act, 1'b0, 1'b0, 4'd7});
        for (int b = 7; b >= 0; b--) begin
            repeat (int'(m_div[s])) q.push_back('{act, 1'b0, d[b], 4'd3});
            repeat (int'(m_div[s])) q.push_back('{act, 1'b1, d[b], 4'd3});
        end
        repeat (int'(m_trail[s])) q.push_back('{act, 1'b0, 1'b0, 4'd8});
    endtask

    // Per-cycle comparison, then model update for this cycle's inputs.
    always @(negedge clk) begin
        if (rst_n && model_on) begin
            exp_t e;
            bit   exp_ready, popped, exp_done;
            exp_ready = (q.size() == 0);
            popped = !exp_ready;
            if (popped) e = q.pop_front();
            else        e = '{4'hF, 1'b0, 1'b0, 4'd9};
            chk(spi_cs_n == e.cs, tag_name(e.tag), spi_cs_n, e.cs);
            chk(spi_sck == e.sck, tag_name(e.tag), spi_sck, e.sck);
            chk(spi_mosi == e.mosi, "R4", spi_mosi, e.mosi);
            chk($countones(~spi_cs_n) <= 1, "R9", spi_cs_n, 4'hF);
            chk(req_ready == exp_ready, "R10", req_ready, exp_ready);
            exp_done = done_pend;
            chk(xfer_done == exp_done, "R10", xfer_done, exp_done);
            if (exp_done && rxq.size() > 0) begin
                logic [7:0] r;
                r = rxq.pop_front();
                chk(rx_data == r, "R4", rx_data, r);
            end
            chk(div_err == err_pend, "R5", div_err, err_pend);
            done_pend = popped && (q.size() == 0);
            err_pend = 1'b0;
            if (req_valid && exp_ready) begin
                if (m_div[req_sel] == 0) err_pend = 1'b1;
                else begin
                    push_xfer(req_sel, req_data);
                    rxq.push_back(miso_byte);
                end
            end
            // R2: field write applied after this cycle's acceptance (R11).
            if (cfg_we) begin
                case (cfg_field)
                    2'd0: m_div[cfg_sel] = cfg_wdata;
                    2'd1: m_lead[cfg_sel] = cfg_wdata;
                    2'd2: m_trail[cfg_sel] = cfg_wdata;
                    default: m_sw = cfg_wdata;
                endcase
            end
        end
    end

    task automatic cfg_write(input logic [1:0] s, input logic [1:0] f, input logic [7:0] v);
        @(posedge clk); #1;
        cfg_we = 1'b1; cfg_sel = s; cfg_field = f; cfg_wdata = v;
        @(posedge clk); #1;
        cfg_we = 1'b0;
    endtask

    task automatic set_sel(input logic [1:0] s, input logic [7:0] dv,
                           input logic [7:0] ld, input logic [7:0] tr);
        cfg_write(s, 2'd0, dv);
        cfg_write(s, 2'd1, ld);
        cfg_write(s, 2'd2, tr);
    endtask

    // Raise a request and return once it has been accepted.
    task automatic xfer(input logic [1:0] s, input logic [7:0] d, input logic [7:0] m);
        @(posedge clk); #1;
        req_valid = 1'b1; req_sel = s; req_data = d; miso_byte = m;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        @(posedge clk); #1;
        req_valid = 1'b0;
        slv = m;
    endtask

    task automatic wait_idle();
        repeat (3) @(negedge clk);
        while (q.size() != 0 || !req_ready) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG) begin
            fails++;
            $display("FAIL watchdog expired after %0d cycles", cycles);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 4; i++) begin
            m_div[i] = '0; m_lead[i] = '0; m_trail[i] = '0;
        end
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state at the pins.
        chk(spi_cs_n == 4'hF, "R1", spi_cs_n, 4'hF);
        chk(spi_sck == 1'b0 && spi_mosi == 1'b0, "R1", {spi_sck, spi_mosi}, 0);
        chk(req_ready == 1'b1, "R1", req_ready, 1);
        chk(xfer_done == 1'b0 && div_err == 1'b0, "R1", {xfer_done, div_err}, 0);
        model_on = 1'b1;

        // R5 with R1: reset divisor is zero, so the request is refused.
        scen = "R5";
        xfer(2'd0, 8'h5A, 8'h00);
        wait_idle();

        scen = "R2";
        set_sel(2'd0, 8'd1, 8'd0, 8'd0);
        set_sel(2'd1, 8'd3, 8'd2, 8'd4);
        set_sel(2'd2, 8'd2, 8'd5, 8'd1);
        set_sel(2'd3, 8'd255, 8'd0, 8'd255);
        cfg_write(2'd2, 2'd3, 8'd3);

        // Back-to-back on one select: no switch gap, done meets next acceptance.
        scen = "R10";
        xfer(2'd0, 8'hA5, 8'h3C);
        xfer(2'd0, 8'h3C, 8'hC3);
        // Select changes: switch gap, lead and trail delays.
        scen = "R6";
        xfer(2'd1, 8'h81, 8'h7E);
        xfer(2'd2, 8'hF0, 8'h0F);
        scen = "R3";
        xfer(2'd3, 8'h96, 8'h69);
        xfer(2'd3, 8'h01, 8'hFE);
        wait_idle();

        // R6: zero switch delay.
        scen = "R6";
        cfg_write(2'd0, 2'd3, 8'd0);
        xfer(2'd0, 8'hC7, 8'h55);
        xfer(2'd1, 8'h18, 8'hAA);

        // R11: divisor written mid-transfer applies only to the next one.
        scen = "R11";
        cfg_write(2'd1, 2'd0, 8'd1);
        xfer(2'd1, 8'h66, 8'h99);
        wait_idle();

        // R11: divisor write in the same cycle as acceptance.
        @(posedge clk); #1;
        cfg_we = 1'b1; cfg_sel = 2'd2; cfg_field = 2'd0; cfg_wdata = 8'd1;
        req_valid = 1'b1; req_sel = 2'd2; req_data = 8'hB4; miso_byte = 8'h4B;
        @(posedge clk); #1;
        cfg_we = 1'b0; req_valid = 1'b0; slv = 8'h4B;
        xfer(2'd2, 8'h2D, 8'hD2);
        wait_idle();

        // R5: divisor cleared later refuses again and leaves selects high.
        scen = "R5";
        cfg_write(2'd0, 2'd0, 8'd0);
        xfer(2'd0, 8'hFF, 8'h00);
        wait_idle();
        scen = "R8";
        xfer(2'd1, 8'hE1, 8'h1E);
        wait_idle();

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule